// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The block follows a chain of command packets held in system memory and forwards their contents to a command consumer. Software gives it a start pointer with a one-cycle strobe. Each node begins with a header word that holds a payload length and the pointer to the next node. The walker fetches the header, then reads each payload word from the words that follow it and presents it on a valid/ready stream. It then moves to the next node. The walk ends when a pointer carries the end-of-list flag.

While it walks, the block adds up an estimate of the bus cost, charged per node and per payload word. It also guards against chains that never end. A checkpoint address is compared against every next pointer. The checkpoint moves forward at node counts that double each time, so a ring is caught even when the walk enters it from an outside tail. When the walk ends, a one-cycle done pulse is raised. The cost total and a loop-error flag stay readable until the next start.

Top module: `chain_walk`

## Requirements
- R1: A header word carries the payload length in bits [31:24] and the next node pointer in bits [23:0].
- R2: The walk ends without any memory fetch for a node whose pointer has bit 23 set; this includes the start pointer itself.
- R3: The 24-bit start pointer is used as given. The memory word index of any pointer is its bits [20:2], so bits [22:21] and [1:0] do not affect where data is read. Read data arrives on `memRdata` in the cycle after `memReq`.
- R4: The payload words of a node come from the memory words directly after its header, in increasing address order. A node of length zero outputs no word.
- R5: While `outValid` is high and `outReady` is low, `outData` holds its value, and no payload fetch is issued.
- R6: Each node adds 10 to the cost, plus 5 plus its length when its length is nonzero. The total is on `costOut` at the done pulse. It is cleared by a new start and unchanged while the block is idle.
- R7: The checkpoint starts at the start pointer. A node whose next pointer equals the checkpoint ends the walk with `loopErr` high, after that node's payload has been output.
- R8: The node counter starts at 0 and counts the nodes already finished. When a node finishes while the counter equals the limit, the checkpoint becomes that node's next pointer and the limit doubles. The limit is 32 after each start.
- R9: `busy` is high from the cycle after an accepted start until the walk ends. `walkDone` is a single-cycle pulse in the first idle cycle. `loopErr` rises only together with `walkDone`.
- R10: A start strobe while the block is busy is ignored.
- R11: After reset the block is idle, with `outValid`, `memReq`, `walkDone` and `loopErr` low and `costOut` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted when idle |
| startAddr | input | 24 | Pointer to the first node |
| memReq | output | 1 | Memory read request |
| memAddr | output | 19 | Memory word index |
| memRdata | input | 32 | Read data, one cycle after request |
| outValid | output | 1 | Payload word available |
| outReady | input | 1 | Consumer accepts the word |
| outData | output | 32 | Payload word |
| busy | output | 1 | Walk in progress |
| walkDone | output | 1 | One-cycle end-of-walk pulse |
| loopErr | output | 1 | Last walk was stopped by loop detection |
| costOut | output | 32 | Cost estimate of the last or current walk |

## Verification
The assertions check the stream handshake on every cycle: the data is held and no fetch is issued during a stall. They also check the done pulse shape, that a loop error appears only with done, that valid appears only while busy, and that the cost is stable while idle. The remaining behaviour needs the bench's prepared chains. These cover the header split and the payload order, the ignored address bits, the cost totals, and both loop cases: a ring back to the start, and a ring entered from a tail that is found only after two checkpoint moves. They also cover the end flag on the start pointer and a start strobe given mid-walk.

// File: rtl/chain_walk_pkg.sv
package chain_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR,
    ST_PREQ,
    ST_PDAT,
    ST_OUT,
    ST_LINK
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldStart;
    logic hdrSel;
    logic ldHdr;
    logic reqWord;
    logic ldWord;
    logic takeWord;
    logic stepLink;
    logic setLoop;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic endFlag;
    logic hdrEmpty;
    logic lastWord;
    logic hitCkpt;
  } dpStat_t;

endpackage

// File: rtl/chain_walk_dp.sv
module chain_walk_dp
  import chain_walk_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 8,
  parameter int MEM_AW     = 19,
  parameter int CYC_W      = 32,
  parameter int CNT_W      = 16,
  parameter int LIMIT_INIT = 32,
  parameter int NODE_COST  = 10,
  parameter int PAY_COST   = 5,
  localparam int DATA_W    = LEN_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  output dpStat_t           stat,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] outData,
  output logic              loopErr,
  output logic [CYC_W-1:0]  costOut
);

  localparam int END_BIT = ADDR_W - 1;
  localparam int BYTE_AW = MEM_AW + 2;

  logic [MEM_AW-1:0] nodeWord;
  logic              endReg;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] ckptAddr;
  logic [CNT_W-1:0]  nodeCnt;
  logic [CNT_W-1:0]  limitCnt;
  logic [MEM_AW-1:0] wordPtr;
  logic [LEN_W-1:0]  remain;
  logic [DATA_W-1:0] holdData;
  logic              loopFlag;
  logic [CYC_W-1:0]  cost;

  logic [LEN_W-1:0]  hdrLen;
  logic [ADDR_W-1:0] hdrNext;
  logic [CYC_W-1:0]  nodeCharge;

  assign hdrLen  = memRdata[DATA_W-1 -: LEN_W];
  assign hdrNext = memRdata[ADDR_W-1:0];

  always_comb begin
    nodeCharge = CYC_W'(NODE_COST);
    if (hdrLen != '0)
      nodeCharge = nodeCharge + CYC_W'(PAY_COST) + CYC_W'(hdrLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nodeWord <= '0;
      endReg   <= 1'b0;
      nextAddr <= '0;
      ckptAddr <= '0;
      nodeCnt  <= '0;
      limitCnt <= CNT_W'(LIMIT_INIT);
      wordPtr  <= '0;
      remain   <= '0;
      holdData <= '0;
      loopFlag <= 1'b0;
      cost     <= '0;
    end else begin
      if (ctl.ldStart) begin
        nodeWord <= startAddr[BYTE_AW-1:2];
        endReg   <= startAddr[END_BIT];
        ckptAddr <= startAddr;
        nodeCnt  <= '0;
        limitCnt <= CNT_W'(LIMIT_INIT);
        loopFlag <= 1'b0;
        cost     <= '0;
      end
      if (ctl.ldHdr) begin
        nextAddr <= hdrNext;
        remain   <= hdrLen;
        wordPtr  <= nodeWord + MEM_AW'(1);
        cost     <= cost + nodeCharge;
      end
      if (ctl.reqWord)
        wordPtr <= wordPtr + MEM_AW'(1);
      if (ctl.ldWord)
        holdData <= memRdata;
      if (ctl.takeWord)
        remain <= remain - LEN_W'(1);
      if (ctl.stepLink) begin
        if (nodeCnt == limitCnt) begin
          ckptAddr <= nextAddr;
          limitCnt <= limitCnt << 1;
        end
        nodeCnt  <= nodeCnt + CNT_W'(1);
        nodeWord <= nextAddr[BYTE_AW-1:2];
        endReg   <= nextAddr[END_BIT];
      end
      if (ctl.setLoop)
        loopFlag <= 1'b1;
    end
  end

  assign memAddr       = ctl.hdrSel ? nodeWord : wordPtr;
  assign stat.endFlag  = endReg;
  assign stat.hdrEmpty = (hdrLen == '0);
  assign stat.lastWord = (remain == LEN_W'(1));
  assign stat.hitCkpt  = (nextAddr == ckptAddr);
  assign outData       = holdData;
  assign loopErr       = loopFlag;
  assign costOut       = cost;

endmodule

// File: rtl/chain_walk_ctrl.sv
module chain_walk_ctrl
  import chain_walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    outReady,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    memReq,
  output logic    outValid,
  output logic    busy,
  output logic    walkDone
);

  walkState_t state, stateNext;
  logic       finish;
  logic       doneQ;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    memReq    = 1'b0;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.ldStart = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (stat.endFlag) begin
          finish    = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.hdrSel = 1'b1;
          memReq     = 1'b1;
          stateNext  = ST_HDR;
        end
      end
      ST_HDR: begin
        ctl.ldHdr = 1'b1;
        stateNext = stat.hdrEmpty ? ST_LINK : ST_PREQ;
      end
      ST_PREQ: begin
        ctl.reqWord = 1'b1;
        memReq      = 1'b1;
        stateNext   = ST_PDAT;
      end
      ST_PDAT: begin
        ctl.ldWord = 1'b1;
        stateNext  = ST_OUT;
      end
      ST_OUT: begin
        if (outReady) begin
          ctl.takeWord = 1'b1;
          if (stat.lastWord) begin
            stateNext = ST_LINK;
          end else begin
            ctl.reqWord = 1'b1;
            memReq      = 1'b1;
            stateNext   = ST_PDAT;
          end
        end
      end
      ST_LINK: begin
        if (stat.hitCkpt) begin
          ctl.setLoop = 1'b1;
          finish      = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          ctl.stepLink = 1'b1;
          stateNext    = ST_CHECK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= finish;
    end
  end

  assign outValid = (state == ST_OUT);
  assign busy     = (state != ST_IDLE);
  assign walkDone = doneQ;

endmodule

// File: rtl/chain_walk.sv
module chain_walk
  import chain_walk_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 8,
  parameter int MEM_AW     = 19,
  parameter int CYC_W      = 32,
  parameter int CNT_W      = 16,
  parameter int LIMIT_INIT = 32,
  localparam int DATA_W    = LEN_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memReq,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              busy,
  output logic              walkDone,
  output logic              loopErr,
  output logic [CYC_W-1:0]  costOut
);

  dpCtrl_t ctl;
  dpStat_t stat;

  chain_walk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .outReady (outReady),
    .stat     (stat),
    .ctl      (ctl),
    .memReq   (memReq),
    .outValid (outValid),
    .busy     (busy),
    .walkDone (walkDone)
  );

  chain_walk_dp #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .MEM_AW     (MEM_AW),
    .CYC_W      (CYC_W),
    .CNT_W      (CNT_W),
    .LIMIT_INIT (LIMIT_INIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .stat      (stat),
    .startAddr (startAddr),
    .memAddr   (memAddr),
    .memRdata  (memRdata),
    .outData   (outData),
    .loopErr   (loopErr),
    .costOut   (costOut)
  );

endmodule

// File: rtl/chain_walk_chk.sv
module chain_walk_chk #(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memReq,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              busy,
  input logic              walkDone,
  input logic              loopErr,
  input logic [CYC_W-1:0]  costOut
);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  assert_no_fetch_stalled_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && outValid && !outReady));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(walkDone) |-> $past(busy) && !busy);

  assert_loop_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopErr) |-> walkDone);

  assert_valid_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  assert_idle_cost_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> $stable(costOut));

endmodule

bind chain_walk chain_walk_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .memReq   (memReq),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .busy     (busy),
  .walkDone (walkDone),
  .loopErr  (loopErr),
  .costOut  (costOut)
);

// File: tb/chain_walk_bench.sv
`timescale 1ns/1ps
module chain_walk_bench;

  typedef struct packed {
    logic [23:0] startAddr;
    logic [1:0]  mode;
    logic [15:0] expWords;
    logic [31:0] expCost;
    logic        expLoop;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{24'h000100, 2'd0, 16'd5,   32'd45,   1'b0},  // R1 R4 R6 plain chain
    '{24'h600100, 2'd1, 16'd5,   32'd45,   1'b0},  // R3 bits 22:21 ignored
    '{24'h000103, 2'd2, 16'd5,   32'd45,   1'b0},  // R3 bits 1:0 ignored
    '{24'h800000, 2'd0, 16'd0,   32'd0,    1'b0},  // R2 end flag on start
    '{24'h000400, 2'd1, 16'd2,   32'd32,   1'b1},  // R7 ring back to start
    '{24'h000600, 2'd0, 16'd0,   32'd10,   1'b1},  // R7 self loop
    '{24'h002000, 2'd0, 16'd0,   32'd1050, 1'b1},  // R8 tail then ring
    '{24'h003000, 2'd1, 16'd255, 32'd270,  1'b0}   // R4 longest payload
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] startAddr = '0;
  logic        memReq;
  logic [18:0] memAddr;
  logic [31:0] memRdata = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outData;
  logic        busy, walkDone, loopErr;
  logic [31:0] costOut;

  always #4 clk = ~clk;

  chain_walk u_chain_walk (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .memReq(memReq), .memAddr(memAddr), .memRdata(memRdata),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .busy(busy), .walkDone(walkDone), .loopErr(loopErr), .costOut(costOut)
  );

  logic [31:0] mem [4096];
  always @(posedge clk) if (memReq) memRdata <= mem[memAddr[11:0]];

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // consumer: ready pattern, capture and stall check at negedge
  logic [1:0]  mode = 2'd0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] rxQ[$];
  logic        prevStall = 1'b0;
  logic [31:0] prevData = '0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (prevStall && outValid)
      check(outData == prevData, "R5", "held data", outData, prevData);
    case (mode)
      2'd0: outReady = 1'b1;
      2'd1: outReady = lfsr[0];
      default: outReady = (lfsr[2:0] == 3'd0);
    endcase
    if (outValid && outReady) rxQ.push_back(outData);
    prevStall = outValid && !outReady;
    prevData  = outData;
  end

  // reference walk built from the requirements
  logic [31:0] expQ[$];
  task automatic refWalk(input logic [23:0] sa);
    logic [23:0] a, ck, nxt;
    int cnt, lim, guard;
    logic [18:0] w;
    logic [31:0] h;
    a = sa; ck = sa; cnt = 0; lim = 32; guard = 0;
    expQ.delete();
    while (!a[23] && guard < 1000) begin
      w = a[20:2];
      h = mem[w[11:0]];
      nxt = h[23:0];
      for (int j = 1; j <= int'(h[31:24]); j++) begin
        logic [18:0] pw;
        pw = w + 19'(j);
        expQ.push_back(mem[pw[11:0]]);
      end
      if (nxt == ck) break;
      if (cnt == lim) begin ck = nxt; lim = lim * 2; end
      cnt++;
      a = nxt;
      guard++;
    end
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (walkDone) begin seen = 1'b1; break; end
    end
  endtask

  task automatic pulseStart(input logic [23:0] a);
    @(negedge clk);
    start = 1'b1; startAddr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runVec(input vec_t v, input bit midStart);
    bit seen;
    refWalk(v.startAddr);
    mode = v.mode;
    rxQ.delete();
    pulseStart(v.startAddr);
    check(busy == 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
    if (midStart) begin
      repeat (20) @(negedge clk);
      start = 1'b1; startAddr = 24'h000100;   // R10 must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    waitDone(seen);
    check(seen, "R9", "done pulse", 32'(seen), 32'd1);
    check(busy == 1'b0, "R9", "idle at done", 32'(busy), 32'd0);
    check(costOut == v.expCost, "R6", "cost", costOut, v.expCost);
    check(loopErr == v.expLoop, v.expLoop ? "R7" : "R2", "loop flag", 32'(loopErr), 32'(v.expLoop));
    check(rxQ.size() == int'(v.expWords), "R4", "word count", 32'(rxQ.size()), 32'(v.expWords));
    check(expQ.size() == int'(v.expWords), "R8", "model word count", 32'(expQ.size()), 32'(v.expWords));
    for (int k = 0; k < rxQ.size() && k < expQ.size(); k++)
      check(rxQ[k] == expQ[k], "R1", "payload word", rxQ[k], expQ[k]);
    @(negedge clk);
    check(walkDone == 1'b0, "R9", "done single cycle", 32'(walkDone), 32'd0);
  endtask

  task automatic buildMem();
    for (int i = 0; i < 4096; i++) mem[i] = 32'hD000_0000 | 32'(i);
    // chain at 0x100: len3 -> 0x200 len0 -> 0x300 len2 -> end
    mem[12'h040] = {8'd3, 24'h000200};
    mem[12'h080] = {8'd0, 24'h000300};
    mem[12'h0C0] = {8'd2, 24'h800000};
    // ring of two back to start
    mem[12'h100] = {8'd1, 24'h000500};
    mem[12'h140] = {8'd1, 24'h000400};
    // self loop
    mem[12'h180] = {8'd0, 24'h000600};
    // five-node tail then forty-node ring
    for (int k = 0; k < 45; k++)
      mem[12'h800 + k] = {8'd0, (k < 44) ? 24'((12'h800 + k + 1) * 4) : 24'(12'h805 * 4)};
    // longest payload
    mem[12'hC00] = {8'd255, 24'h800000};
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    buildMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 0 && outValid == 0 && memReq == 0, "R11", "idle outputs",
          {29'd0, busy, outValid, memReq}, 32'd0);
    check(walkDone == 0 && loopErr == 0, "R11", "flags", {30'd0, walkDone, loopErr}, 32'd0);
    check(costOut == 0, "R11", "cost", costOut, 32'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], 1'b0);

    // R10 start while busy on the long ring walk
    runVec(VECS[6], 1'b1);
    // loop flag cleared by a following clean walk (R7)
    runVec(VECS[0], 1'b0);
    // R6 cost unchanged while idle
    repeat (10) @(negedge clk);
    check(costOut == 32'd45, "R6", "idle cost", costOut, 32'd45);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule